// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

A memory-mapped watchdog built around a down-counter that steps once per clock while running. When the counter runs out the first time, the block raises an interrupt and starts a fresh period from the programmed period value. If software has still not serviced that interrupt when the counter runs out again, the block asserts a system reset. A full reset therefore needs two unserviced periods. Software services the watchdog by writing the interrupt-clear register. That write drops the pending interrupt and restarts the count.

All registers except the key register are protected. A write of the magic key to the key register opens the register file. A write of any other value to it closes the register file again. The block leaves reset closed, with the counter stopped. A driver starts the watchdog in this order: it writes the key, writes the period, writes the interrupt-clear register so that the new period is loaded, sets the control bits, and then closes the register file.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the key register reads 1 (closed), control reads 0, both the period and the counter read 0xFFFFFFFF, status reads 0, and `irq_o` and `sys_rst_o` are low.
- R2: A write of 0x1ACCE551 to the key register (offset 0xC00) opens the register file, and the key register then reads 0. A write of any other value closes it, and it then reads 1.
- R3: While the register file is closed, writes to period (0x000), control (0x008) and interrupt-clear (0x00C) have no effect.
- R4: While control bit 1 is set, the counter (readable at 0x004) drops by one on each clock. While control bit 1 is clear, the counter holds its value.
- R5: When the counter is at 0 and running, the next clock reloads it from the period register and sets the pending flag. Status (0x014) then reads 1, and `irq_o` equals the pending flag ANDed with control bit 1.
- R6: Any write to interrupt-clear while the register file is open clears the pending flag and loads the counter from the period register. If the write lands on the same clock as an expiry, the clear wins and no interrupt is raised.
- R7: An expiry while the pending flag is set asserts `sys_rst_o`, but only if control bit 0 is set. Once asserted, `sys_rst_o` stays high until block reset, even if an interrupt clear follows.
- R8: A write to the period register does not change the running count. The new value takes effect at the next reload or interrupt clear.
- R9: Control bits 31:2 are reserved, are not stored, and read as 0.
- R10: The period register accepts 0xFFFFFFFF, and the counter then counts down from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the counter tick |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Watchdog interrupt |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and data path, a 12-bit offset space and the standard key. With the full 32-bit width, the bench can load a period of 0xFFFFFFFF and watch the counter step down from it. The bench also uses periods of only a few cycles, so it can reach both expiry stages and the clock where a clear and an expiry coincide within a few dozen cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int OFS_PERIOD = 'h000;
   localparam int OFS_COUNT  = 'h004;
   localparam int OFS_CTRL   = 'h008;
   localparam int OFS_CLEAR  = 'h00C;
   localparam int OFS_STATUS = 'h014;
   localparam int OFS_KEY    = 'hC00;
   localparam int CTRL_W     = 2;
   localparam int CTRL_RSTEN = 0;
   localparam int CTRL_RUN   = 1;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int              ADDR_W = 12,
   parameter int              DATA_W = 32,
   parameter int              CNT_W  = 32,
   parameter logic [DATA_W-1:0] KEY  = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              pend_i,
   output logic [CNT_W-1:0]  period_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              clear_o,
   output logic              locked_o
);
   logic sel_period, sel_count, sel_ctrl, sel_clear, sel_status, sel_key;
   logic wr_ok;
   logic [DATA_W-1:0] cnt_ext, period_ext;

   assign sel_period = (bus_addr == ADDR_W'(OFS_PERIOD));
   assign sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
   assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_clear  = (bus_addr == ADDR_W'(OFS_CLEAR));
   assign sel_status = (bus_addr == ADDR_W'(OFS_STATUS));
   assign sel_key    = (bus_addr == ADDR_W'(OFS_KEY));
   assign wr_ok      = bus_we & ~locked_o;
   assign clear_o    = wr_ok & sel_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_o <= 1'b1;
         period_o <= '1;
         ctrl_o   <= '0;
      end else begin
         if (bus_we && sel_key)
            locked_o <= (bus_wdata != KEY);
         if (wr_ok && sel_period)
            period_o <= bus_wdata[CNT_W-1:0];
         if (wr_ok && sel_ctrl)
            ctrl_o <= bus_wdata[CTRL_W-1:0];
      end
   end

   generate
      if (CNT_W == DATA_W) begin : g_full
         assign cnt_ext    = cnt_i;
         assign period_ext = period_o;
      end else begin : g_pad
         assign cnt_ext    = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
         assign period_ext = {{(DATA_W-CNT_W){1'b0}}, period_o};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_period)      bus_rdata = period_ext;
      else if (sel_count)  bus_rdata = cnt_ext;
      else if (sel_ctrl)   bus_rdata = DATA_W'(ctrl_o);
      else if (sel_status) bus_rdata = DATA_W'(pend_i);
      else if (sel_key)    bus_rdata = DATA_W'(locked_o);
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   logic at_zero;
   assign at_zero  = (cnt_o == '0);
   assign expire_o = run_i & at_zero & ~reload_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '1;
      else if (reload_i)
         cnt_o <= period_i;
      else if (run_i) begin
         if (at_zero) cnt_o <= period_i;
         else         cnt_o <= cnt_o - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic clear_i,
   input  logic rst_en_i,
   input  logic run_i,
   output logic pend_o,
   output logic irq_o,
   output logic sys_rst_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o    <= 1'b0;
         sys_rst_o <= 1'b0;
      end else begin
         if (clear_i)       pend_o <= 1'b0;
         else if (expire_i) pend_o <= 1'b1;
         if (expire_i && pend_o && rst_en_i)
            sys_rst_o <= 1'b1;
      end
   end
   assign irq_o = pend_o & run_i;
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
   import wdog_pkg::*;
#(
   parameter int              ADDR_W = 12,
   parameter int              DATA_W = 32,
   parameter int              CNT_W  = 32,
   parameter logic [DATA_W-1:0] KEY  = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              sys_rst_o
);
   generate
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("wdog_lockable: CNT_W must be 2..DATA_W");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("wdog_lockable: ADDR_W must reach offset 0xC00");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("wdog_lockable: DATA_W too narrow for control");
      end
   endgenerate

   logic [CNT_W-1:0]  period_val, cnt;
   logic [CTRL_W-1:0] ctrl;
   logic              clear_pulse, locked, expire, pend;

   wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_i(cnt), .pend_i(pend),
      .period_o(period_val), .ctrl_o(ctrl), .clear_o(clear_pulse), .locked_o(locked)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(ctrl[CTRL_RUN]), .reload_i(clear_pulse),
      .period_i(period_val), .cnt_o(cnt), .expire_o(expire)
   );

   wdog_stage u_stage (
      .clk(clk), .rst_n(rst_n), .expire_i(expire), .clear_i(clear_pulse),
      .rst_en_i(ctrl[CTRL_RSTEN]), .run_i(ctrl[CTRL_RUN]), .pend_o(pend),
      .irq_o(irq_o), .sys_rst_o(sys_rst_o)
   );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
   import wdog_pkg::*;
#(
   parameter int              ADDR_W = 12,
   parameter int              DATA_W = 32,
   parameter int              CNT_W  = 32,
   parameter logic [DATA_W-1:0] KEY  = 32'h1ACCE551
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [CTRL_W-1:0] ctrl,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  period_val,
   input logic              pend,
   input logic              clear_pulse,
   input logic              locked,
   input logic              irq_o,
   input logic              sys_rst_o
);
   assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == ADDR_W'(OFS_KEY) && bus_wdata == KEY |=> !locked);

   assert_closed_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !(bus_we && bus_addr == ADDR_W'(OFS_KEY)) |=> $stable(ctrl) && $stable(period_val));

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CTRL_RUN] && cnt != '0 && !clear_pulse |=> cnt == $past(cnt) - CNT_W'(1));

   assert_irq_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend && ctrl[CTRL_RUN]);

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse |=> !pend && cnt == $past(period_val));

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> sys_rst_o);

   assert_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(pend) && $past(ctrl[CTRL_RSTEN]));
endmodule

bind wdog_lockable wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
   .ctrl(ctrl), .cnt(cnt), .period_val(period_val), .pend(pend), .clear_pulse(clear_pulse),
   .locked(locked), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/tb_wdog_lockable.sv
module tb_wdog_lockable;
   localparam logic [31:0] KEY = 32'h1ACCE551;
   localparam logic [11:0] A_PER = 12'h000, A_CNT = 12'h004, A_CTL = 12'h008,
                           A_CLR = 12'h00C, A_STA = 12'h014, A_KEY = 12'hC00;

   logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic irq_o, sys_rst_o;
   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdog_lockable dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_we = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(A_KEY, v); chk("R1 key", v, 1);
      rd(A_CTL, v); chk("R1 ctrl", v, 0);
      rd(A_PER, v); chk("R1 period", v, 32'hFFFFFFFF);
      rd(A_CNT, v); chk("R1 count", v, 32'hFFFFFFFF);
      rd(A_STA, v); chk("R1 status", v, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 rst", sys_rst_o, 0);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(A_KEY, KEY);          rd(A_KEY, v); chk("R2 open", v, 0);
      wr(A_KEY, 32'h12345678); rd(A_KEY, v); chk("R2 close", v, 1);
   endtask

   task automatic t_closed();
      logic [31:0] v;
      wr(A_KEY, 0);
      wr(A_CTL, 2); wr(A_PER, 7); wr(A_CLR, 1);
      rd(A_CTL, v); chk("R3 ctrl ignored", v, 0);
      rd(A_PER, v); chk("R3 period ignored", v, 32'hFFFFFFFF);
      rd(A_CNT, v); chk("R3 clear ignored", v, 32'hFFFFFFFF);
   endtask

   task automatic t_count();
      logic [31:0] v;
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 20); wr(A_CLR, 0);
      rd(A_CNT, v); chk("R4 loaded", v, 20);
      wr(A_CTL, 32'hFFFFFFF2);
      rd(A_CTL, v); chk("R9 reserved zero", v, 2);
      rd(A_CNT, v); chk("R4 start", v, 20);
      repeat (3) @(negedge clk);
      rd(A_CNT, v); chk("R4 step", v, 17);
      wr(A_CTL, 0);
      rd(A_CNT, v); chk("R4 stop", v, 15);
      repeat (4) @(negedge clk);
      rd(A_CNT, v); chk("R4 hold", v, 15);
   endtask

   task automatic t_expiry();
      logic [31:0] v;
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 5); wr(A_CLR, 0); wr(A_CTL, 2);
      repeat (5) @(negedge clk);
      rd(A_CNT, v); chk("R5 zero", v, 0);
      rd(A_STA, v); chk("R5 not yet", v, 0);
      @(negedge clk);
      rd(A_STA, v); chk("R5 status", v, 1);
      rd(A_CNT, v); chk("R5 reload", v, 5);
      chk("R5 irq", irq_o, 1);
      wr(A_CTL, 0);
      chk("R5 irq masked", irq_o, 0);
      wr(A_CTL, 2);
      wr(A_CLR, 1);
      rd(A_STA, v); chk("R6 cleared", v, 0);
      rd(A_CNT, v); chk("R6 reload", v, 5);
      chk("R6 irq low", irq_o, 0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 2); wr(A_CLR, 0); wr(A_CTL, 2);
      @(negedge clk);
      wr(A_CLR, 0);
      rd(A_STA, v); chk("R6 clear wins", v, 0);
      rd(A_CNT, v); chk("R6 race count", v, 2);
      repeat (3) @(negedge clk);
      rd(A_STA, v); chk("R6 later expiry", v, 1);
   endtask

   task automatic t_second();
      logic [31:0] v;
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 3); wr(A_CLR, 0); wr(A_CTL, 3);
      repeat (4) @(negedge clk);
      chk("R7 first stage irq", irq_o, 1);
      chk("R7 first stage no rst", sys_rst_o, 0);
      repeat (3) @(negedge clk);
      chk("R7 before second", sys_rst_o, 0);
      @(negedge clk);
      chk("R7 second stage rst", sys_rst_o, 1);
      wr(A_CLR, 0);
      repeat (3) @(negedge clk);
      chk("R7 sticky", sys_rst_o, 1);
      rd(A_STA, v); chk("R7 pend cleared", v, 0);
      do_reset();
      chk("R7 released by reset", sys_rst_o, 0);
   endtask

   task automatic t_no_rst();
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 3); wr(A_CLR, 0); wr(A_CTL, 2);
      repeat (18) @(negedge clk);
      chk("R7 no rst without bit0", sys_rst_o, 0);
      chk("R7 irq still", irq_o, 1);
   endtask

   task automatic t_defer();
      logic [31:0] v;
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 10); wr(A_CLR, 0); wr(A_CTL, 2);
      wr(A_PER, 3);
      rd(A_PER, v); chk("R8 period stored", v, 3);
      rd(A_CNT, v); chk("R8 count untouched", v, 8);
      repeat (8) @(negedge clk);
      rd(A_CNT, v); chk("R8 zero", v, 0);
      @(negedge clk);
      rd(A_CNT, v); chk("R8 new period at reload", v, 3);
      wr(A_PER, 9); wr(A_CLR, 0);
      rd(A_CNT, v); chk("R8 new period at clear", v, 9);
   endtask

   task automatic t_max();
      logic [31:0] v;
      do_reset(); wr(A_KEY, KEY);
      wr(A_PER, 0); wr(A_CLR, 0);
      rd(A_CNT, v); chk("R10 zero first", v, 0);
      wr(A_PER, 32'hFFFFFFFF); wr(A_CLR, 0);
      rd(A_CNT, v); chk("R10 max load", v, 32'hFFFFFFFF);
      wr(A_CTL, 2);
      @(negedge clk);
      rd(A_CNT, v); chk("R10 max step", v, 32'hFFFFFFFE);
   endtask

   initial begin
      t_reset();
      t_lock();
      t_closed();
      t_count();
      t_expiry();
      t_race();
      t_second();
      t_no_rst();
      t_defer();
      t_max();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule